// File: doc/BRIEF.md
# Rotating-Wiring Layered LDPC Decoder

This core decodes one codeword of a small quasi-cyclic LDPC code with layered normalized min-sum message passing. The parity-check matrix is cut into U column groups of Z columns and into Y = U layers of Z rows. Only one layer of check-node units is built (Z of them), plus one soft-value register per code column. The check nodes reach the soft values through one constant wiring pattern. After every processed layer the column groups of the soft-value registers move one group to the right. The same fixed wires therefore meet a different group arrangement in each layer, and no per-layer selection logic is needed. After Y layers the groups are back in their natural positions.

The user presents N = U*Z channel LLRs in parallel together with a one-cycle `start_i`, and an iteration limit on `max_iter_i`. The core then runs one layer per clock cycle. At the end of each iteration it registers the hard decisions. After the last iteration it raises `done_o` for one cycle. The controller has three states. ST_IDLE waits for a start. ST_DECODE processes the layers. ST_DONE lasts one cycle and flags completion. The transitions are: idle to decode on `start_i`; decode to done on the last layer of the last iteration; done to decode on `start_i`, otherwise done to idle.

Top module: `ldpc_rot_dec`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `hard_o` is all zeros.
- R2: A `start_i` sampled while the core is not in ST_DECODE loads `llr_i`, with column j at bits [6j+5:6j] in signed two's complement. It clears all stored check messages, and `busy_o` is 1 in the next cycle. A `start_i` sampled while the core is in ST_DECODE is ignored: neither the data nor the timing of the run changes.
- R3: The core processes one layer per clock edge, in the order 0, 1, …, Y-1 within each iteration. Counting the loading edge as edge 0, `done_o` is high for exactly one cycle, after edge Y*iterations.
- R4: A `max_iter_i` of 0 runs one iteration.
- R5: A check node forms the magnitude it sends back on an edge from the smallest input magnitude among its other edges. It then scales that value by 0.75, computed as m − (m>>2), and limits it to 15. The sign is the XOR of the signs of the other edges' inputs, with zero counted as positive.
- R6: For each edge, Q = sat(L − R_old), and the new soft value is L = sat(Q + R_new), where sat limits to ±31. R_new replaces R_old in a store indexed by layer, row and edge.
- R7: In layer k, the submatrix of column group g is chosen by position p = (g+k) mod U. When p mod 4 = 2, the submatrix is all zero. Otherwise it is a circulant with shift s = (3p+1) mod Z, so row r meets column g*Z + (r+s) mod Z.
- R8: `hard_o[j]` is 1 exactly when the soft value of column j is negative. It is updated in natural column order at the end of each iteration and holds between those updates.
- R9: After every iteration, the hard decisions match, bit for bit, a layered normalized min-sum decoder that addresses the columns directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load LLRs and start a decode |
| max_iter_i | input | ITW (4) | Iteration limit, 0 treated as 1 |
| llr_i | input | N*LW (96) | Channel LLRs, column j at [LW*j +: LW] |
| hard_o | output | N (16) | Hard decisions, bit j is column j |
| busy_o | output | 1 | High while layers are being processed |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The hardest condition to reach from the ports is a start request that arrives in the middle of a decode. Such a request must leave both the loaded data and the run length untouched. The stimulus raises `start_i` two cycles into a run and inverts every LLR bit at the same moment. It then requires the hard decisions of each iteration, and the cycle in which `done_o` rises, to match the undisturbed reference. Seeded random LLRs with iteration limits from 0 to 5 drive the check messages into saturation and into ties for the minimum. This exercises the per-layer message store across several iterations.

// File: rtl/ldpc_rot_pkg.sv
package ldpc_rot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_DONE   = 2'd2
    } dec_state_e;

    // circulant shift seen at wiring position pos, -1 for an empty submatrix
    function automatic int col_shift(input int pos, input int zs);
        if ((pos % 4) == 2) return -1;
        return (3 * pos + 1) % zs;
    endfunction

    // number of populated positions below 'upto' = edge index of that position
    function automatic int edge_count(input int upto, input int zs);
        int c;
        c = 0;
        for (int q = 0; q < upto; q++)
            if (col_shift(q, zs) >= 0) c++;
        return c;
    endfunction

    function automatic int edge_pos(input int e, input int ups, input int zs);
        for (int p = 0; p < ups; p++)
            if (col_shift(p, zs) >= 0 && edge_count(p, zs) == e) return p;
        return 0;
    endfunction

    function automatic int sat_val(input int v, input int w);
        int lim;
        lim = (1 << (w - 1)) - 1;
        if (v > lim) return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

endpackage

// File: rtl/ldpc_rot_ctrl.sv
module ldpc_rot_ctrl
    import ldpc_rot_pkg::*;
#(
    parameter int Y   = 4,
    parameter int ITW = 4,
    parameter int LYW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [ITW-1:0] max_iter_i,
    output logic           load_o,
    output logic           step_o,
    output logic [LYW-1:0] layer_o,
    output logic           iter_end_o,
    output logic           busy_o,
    output logic           done_o
);
    localparam logic [LYW-1:0] LAST_LAYER = LYW'(Y - 1);

    dec_state_e     state_q, state_d;
    logic [LYW-1:0] layer_q;
    logic [ITW-1:0] iter_q, lim_q;
    logic           accept, last_layer, last_iter;

    assign accept     = start_i && (state_q != ST_DECODE);
    assign last_layer = (layer_q == LAST_LAYER);
    assign last_iter  = (iter_q == lim_q - 1'b1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_DECODE;
            ST_DECODE: if (last_layer && last_iter) state_d = ST_DONE;
            ST_DONE:   state_d = start_i ? ST_DECODE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            layer_q <= '0;
            iter_q  <= '0;
            lim_q   <= ITW'(1);
        end else begin
            state_q <= state_d;
            if (accept) begin
                layer_q <= '0;
                iter_q  <= '0;
                lim_q   <= (max_iter_i == '0) ? ITW'(1) : max_iter_i;
            end else if (state_q == ST_DECODE) begin
                if (last_layer) begin
                    layer_q <= '0;
                    iter_q  <= iter_q + 1'b1;
                end else begin
                    layer_q <= layer_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        busy_o     = (state_q == ST_DECODE);
        step_o     = (state_q == ST_DECODE);
        load_o     = accept;
        layer_o    = layer_q;
        iter_end_o = (state_q == ST_DECODE) && last_layer;
        done_o     = (state_q == ST_DONE);
    end

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_layer_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last_layer) |=> (busy_o && layer_q == $past(layer_q) + 1'b1));
    assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(iter_end_o));
    assert_start_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && layer_q == '0));

endmodule

// File: rtl/ldpc_rot_cnu.sv
module ldpc_rot_cnu
    import ldpc_rot_pkg::*;
#(
    parameter int D   = 3,
    parameter int Y   = 4,
    parameter int LW  = 6,
    parameter int RW  = 5,
    parameter int LYW = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 step_i,
    input  logic [LYW-1:0]       layer_i,
    input  logic signed [LW-1:0] l_in  [D],
    output logic signed [LW-1:0] l_out [D]
);
    localparam int MW   = LW - 1;
    localparam int RMAX = (1 << (RW - 1)) - 1;

    logic signed [RW-1:0] r_q   [Y][D];
    logic signed [RW-1:0] r_new [D];
    logic signed [LW-1:0] q_v   [D];
    logic [MW-1:0]        mag   [D];
    logic                 sgn   [D];

    always_comb begin
        int  min1, min2, idx, m, sc;
        logic par;
        min1 = (1 << MW) - 1;
        min2 = (1 << MW) - 1;
        idx  = 0;
        par  = 1'b0;
        for (int e = 0; e < D; e++) begin
            q_v[e] = LW'(sat_val(int'(l_in[e]) - int'(r_q[layer_i][e]), LW));
            sgn[e] = q_v[e][LW-1];
            mag[e] = sgn[e] ? MW'(-q_v[e]) : MW'(q_v[e]);
            if (int'(mag[e]) < min1) begin
                min2 = min1;
                min1 = int'(mag[e]);
                idx  = e;
            end else if (int'(mag[e]) < min2) begin
                min2 = int'(mag[e]);
            end
            par = par ^ sgn[e];
        end
        for (int e = 0; e < D; e++) begin
            m  = (idx == e) ? min2 : min1;
            sc = m - (m >> 2);
            if (sc > RMAX) sc = RMAX;
            r_new[e] = RW'((par ^ sgn[e]) ? -sc : sc);
            l_out[e] = LW'(sat_val(int'(q_v[e]) + int'(r_new[e]), LW));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            for (int y = 0; y < Y; y++)
                for (int e = 0; e < D; e++)
                    r_q[y][e] <= '0;
        end else if (step_i) begin
            for (int e = 0; e < D; e++)
                r_q[layer_i][e] <= r_new[e];
        end
    end

    for (genvar y = 0; y < Y; y++) begin : g_chk_y
        for (genvar e = 0; e < D; e++) begin : g_chk_e
            assert_msg_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
                r_q[y][e] != {1'b1, {(RW-1){1'b0}}});
            assert_msg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (!step_i && !clr_i) |=> $stable(r_q[y][e]));
            assert_msg_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
                clr_i |=> (r_q[y][e] == '0));
        end
    end

endmodule

// File: rtl/ldpc_rot_vnb.sv
module ldpc_rot_vnb
    import ldpc_rot_pkg::*;
#(
    parameter int U  = 4,
    parameter int Z  = 4,
    parameter int D  = 3,
    parameter int LW = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic [U*Z*LW-1:0]      llr_i,
    input  logic                   step_i,
    input  logic                   iter_end_i,
    input  logic signed [LW-1:0]   e_out [Z][D],
    output logic signed [LW-1:0]   col_l [U*Z],
    output logic [U*Z-1:0]         hard_o
);
    localparam int N = U * Z;

    logic signed [LW-1:0] l_q [N];
    logic signed [LW-1:0] upd [N];
    logic signed [LW-1:0] nxt [N];
    logic [N-1:0]         hard_q;

    for (genvar j = 0; j < N; j++) begin : g_col
        localparam int P = j / Z;
        localparam int C = j % Z;
        localparam int S = col_shift(P, Z);
        if (S >= 0) begin : g_wired
            localparam int R = (C - S + Z) % Z;
            localparam int E = edge_count(P, Z);
            assign upd[j] = e_out[R][E];
        end else begin : g_open
            assign upd[j] = l_q[j];
        end
        assign nxt[j]   = upd[(j + N - Z) % N];
        assign col_l[j] = l_q[j];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < N; j++) l_q[j] <= '0;
            hard_q <= '0;
        end else if (load_i) begin
            for (int j = 0; j < N; j++) l_q[j] <= llr_i[j*LW +: LW];
        end else if (step_i) begin
            for (int j = 0; j < N; j++) l_q[j] <= nxt[j];
            if (iter_end_i)
                for (int j = 0; j < N; j++) hard_q[j] <= nxt[j][LW-1];
        end
    end

    assign hard_o = hard_q;

    assert_hard_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !iter_end_i |=> $stable(hard_q));

    for (genvar p = 0; p < U; p++) begin : g_zero_grp
        if (col_shift(p, Z) < 0) begin : g_chk
            assert_zero_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (step_i && !load_i) |=> (l_q[((p + 1) % U) * Z] == $past(l_q[p * Z])));
        end
    end

endmodule

// File: rtl/ldpc_rot_dec.sv
module ldpc_rot_dec
    import ldpc_rot_pkg::*;
#(
    parameter int U   = 4,
    parameter int Z   = 4,
    parameter int LW  = 6,
    parameter int RW  = 5,
    parameter int ITW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ITW-1:0]      max_iter_i,
    input  logic [U*Z*LW-1:0]   llr_i,
    output logic [U*Z-1:0]      hard_o,
    output logic                busy_o,
    output logic                done_o
);
    localparam int N   = U * Z;
    localparam int Y   = U;
    localparam int D   = edge_count(U, Z);
    localparam int LYW = (Y > 1) ? $clog2(Y) : 1;

    logic           load, step, iter_end;
    logic [LYW-1:0] layer;

    logic signed [LW-1:0] col_l [N];
    logic signed [LW-1:0] e_in  [Z][D];
    logic signed [LW-1:0] e_out [Z][D];

    ldpc_rot_ctrl #(.Y(Y), .ITW(ITW), .LYW(LYW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .max_iter_i (max_iter_i),
        .load_o     (load),
        .step_o     (step),
        .layer_o    (layer),
        .iter_end_o (iter_end),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    for (genvar r = 0; r < Z; r++) begin : g_row
        for (genvar e = 0; e < D; e++) begin : g_edge
            localparam int P   = edge_pos(e, U, Z);
            localparam int S   = col_shift(P, Z);
            localparam int COL = P * Z + (r + S) % Z;
            assign e_in[r][e] = col_l[COL];
        end
        ldpc_rot_cnu #(.D(D), .Y(Y), .LW(LW), .RW(RW), .LYW(LYW)) u_cnu (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (load),
            .step_i  (step),
            .layer_i (layer),
            .l_in    (e_in[r]),
            .l_out   (e_out[r])
        );
    end

    ldpc_rot_vnb #(.U(U), .Z(Z), .D(D), .LW(LW)) u_vnb (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .llr_i      (llr_i),
        .step_i     (step),
        .iter_end_i (iter_end),
        .e_out      (e_out),
        .col_l      (col_l),
        .hard_o     (hard_o)
    );

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

endmodule

// File: tb/ldpc_rot_dec_tb.sv
`timescale 1ns/1ps
module ldpc_rot_dec_tb;
    localparam int U = 4, Z = 4, LW = 6, RW = 5, ITW = 4;
    localparam int N = U * Z, Y = U;
    localparam int RMAX = (1 << (RW - 1)) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ITW-1:0]    max_iter_i = '0;
    logic [N*LW-1:0]   llr_i = '0;
    logic [N-1:0]      hard_o;
    logic              busy_o, done_o;

    int vec_n = 0, bad_n = 0;
    int gl [N];
    int gr [Y][Z][U];
    int llr_v [N];

    always #2.5 clk = ~clk;

    ldpc_rot_dec #(.U(U), .Z(Z), .LW(LW), .RW(RW), .ITW(ITW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .max_iter_i(max_iter_i),
        .llr_i(llr_i), .hard_o(hard_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic int bsat(input int v);
        if (v > 31) return 31;
        if (v < -31) return -31;
        return v;
    endfunction

    function automatic int bsh(input int p);
        if ((p % 4) == 2) return -1;
        return (3 * p + 1) % Z;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        vec_n++;
        if (!ok) begin
            bad_n++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic gold_layer(input int k);
        for (int r = 0; r < Z; r++) begin
            int qv [U];
            int col [U];
            bit on [U];
            int m1, m2, ix, m, sc, rn;
            bit sp;
            m1 = 1000; m2 = 1000; ix = -1; sp = 0;
            for (int g = 0; g < U; g++) begin
                int s;
                s = bsh((g + k) % U);
                on[g] = (s >= 0);
                if (on[g]) begin
                    int mg;
                    col[g] = g * Z + (r + s) % Z;
                    qv[g] = bsat(gl[col[g]] - gr[k][r][g]);
                    mg = (qv[g] < 0) ? -qv[g] : qv[g];
                    if (mg < m1) begin m2 = m1; m1 = mg; ix = g; end
                    else if (mg < m2) m2 = mg;
                    sp = sp ^ (qv[g] < 0);
                end
            end
            for (int g = 0; g < U; g++) begin
                if (on[g]) begin
                    m  = (g == ix) ? m2 : m1;
                    sc = m - (m >> 2);
                    if (sc > RMAX) sc = RMAX;
                    rn = (sp ^ (qv[g] < 0)) ? -sc : sc;
                    gr[k][r][g] = rn;
                    gl[col[g]] = bsat(qv[g] + rn);
                end
            end
        end
    endtask

    function automatic int gold_hard();
        int h;
        h = 0;
        for (int j = 0; j < N; j++) if (gl[j] < 0) h |= (1 << j);
        return h;
    endfunction

    task automatic run_dec(input int it, input bit poke);
        int eff;
        string rq;
        eff = (it == 0) ? 1 : it;
        rq  = (it == 0) ? "R4" : "R3";
        for (int j = 0; j < N; j++) begin
            gl[j] = bsat(llr_v[j]) == llr_v[j] ? llr_v[j] : llr_v[j];
            llr_i[j*LW +: LW] = LW'(llr_v[j]);
        end
        for (int y = 0; y < Y; y++)
            for (int r = 0; r < Z; r++)
                for (int g = 0; g < U; g++) gr[y][r][g] = 0;
        @(negedge clk);
        max_iter_i = ITW'(it);
        start_i = 1'b1;
        for (int n = 0; n <= Y * eff + 1; n++) begin
            @(negedge clk);
            if (n == 0) begin
                start_i = 1'b0;
                chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
            end
            if (poke && n == 1) begin llr_i = ~llr_i; start_i = 1'b1; end
            if (poke && n == 2) start_i = 1'b0;
            if (n > 0 && (n % Y) == 0 && n <= Y * eff) begin
                for (int k = 0; k < Y; k++) gold_layer(k);
                chk(int'(hard_o) == gold_hard(), poke ? "R2" : "R9",
                    "hard decisions after iteration", int'(hard_o), gold_hard());
            end
            if (n == Y * eff - 1)
                chk(done_o == 1'b0, rq, "done early", done_o, 0);
            if (n == Y * eff)
                chk(done_o == 1'b1, rq, "done on time", done_o, 1);
            if (n == Y * eff + 1)
                chk(done_o == 1'b0, "R3", "done one cycle", done_o, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad_n++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        // R1: outputs during and just after reset
        chk(busy_o == 1'b0 && done_o == 1'b0, "R1", "flags in reset", {busy_o, done_o}, 0);
        chk(hard_o == '0, "R1", "hard in reset", int'(hard_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0 && done_o == 1'b0 && hard_o == '0, "R1", "idle after reset",
            int'(hard_o), 0);

        // directed: strong positive, strong negative (-32 saturates, R6), alternating, weak
        for (int j = 0; j < N; j++) llr_v[j] = 31;
        run_dec(2, 1'b0);
        for (int j = 0; j < N; j++) llr_v[j] = -32;
        run_dec(3, 1'b0);
        for (int j = 0; j < N; j++) llr_v[j] = (j % 2) ? -9 : 12;
        run_dec(0, 1'b0);                       // R4
        for (int j = 0; j < N; j++) llr_v[j] = (j == 5) ? -1 : 2;
        run_dec(4, 1'b0);                       // R5 tie and weak-bit correction
        // R2: start during a run with altered data
        for (int j = 0; j < N; j++) llr_v[j] = int'($urandom_range(63)) - 32;
        run_dec(3, 1'b1);

        // random runs, R5..R9 against the direct-indexing reference
        for (int t = 0; t < 40; t++) begin
            for (int j = 0; j < N; j++) llr_v[j] = int'($urandom_range(63)) - 32;
            run_dec(int'($urandom_range(5)), (t % 8) == 3);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

endmodule